// File: doc/BRIEF.md
# Dual-Port Memory with Same-Location Busy Arbitration

This block is a synchronous memory of 2048 words of 16 bits with two fully independent ports, left and right. Each port has its own address, write data, read data, an active-low enable and a pair of active-low byte write enables. Either port can read or write any word in any cycle. There is no separate refresh step for cross-port traffic: what one port writes is read back by the other port at the same word.

When both enabled ports point at the same word, the block resolves the collision. The port that was already on that word in the previous cycle keeps it. If both arrive in the same cycle, the left port wins. The losing port sees its active-low busy output go low in the same cycle. Busy holds off the losing port's writes but never its reads. A write that is held off completes on the first edge after busy clears, provided the write enables are still low.

A parameter selects master or slave operation. In master mode the block arbitrates and drives busy. In slave mode it does no arbitration: its busy outputs stay high, and each port's busy input only gates that port's writes. This lets a second instance follow the decision of a master.

Top module: `dualport_busy_ram`

## Requirements
- R1: A port writes on a rising clock edge only if its enable is low, at least one of its byte write enables is low, and the write is not held off by busy. With the enable high, or both write enables high, the stored word stays unchanged.
- R2: Write enable bit 1 selects data bits 15:8 and bit 0 selects bits 7:0, both active low. Each byte can be written on its own and leaves the other byte as it was.
- R3: Read data is registered. It shows the word at the address captured on the edge where the enable was low, holds its value while the enable is high, and resets to zero.
- R4: A word written through one port is returned on the other port by a read captured on any later edge. A read captured on the same edge returns the old word.
- R5: In master mode exactly one busy output is low whenever both enables are low and the addresses are equal. Both busy outputs are never low at the same time.
- R6: In master mode a port that was enabled at the same address in the previous cycle wins against a port that has just arrived, and the arriving port gets busy.
- R7: In master mode, when neither port was already on the shared address, the left port wins and the right port gets busy.
- R8: A port with busy low does not write. If it keeps its write enables low, its write happens on the first edge after busy is released.
- R9: Busy is high on both ports when the addresses differ or either enable is high. It changes in the same cycle as the inputs, with no clock edge in between.
- R10: In slave mode both busy outputs stay high, and a low busy input holds off writes on that port only. Reads on that port still work.
- R11: In master mode the busy inputs have no effect on writes.
- R12: In master mode the winner is kept for as long as both ports stay on the same shared address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| lfAddr | input | 11 | Left port word address |
| lfDin | input | 16 | Left port write data |
| lfCeN | input | 1 | Left port enable, active low |
| lfWeN | input | 2 | Left byte write enables, active low (bit 1 upper, bit 0 lower) |
| lfBusyInN | input | 1 | Left busy input, active low, used in slave mode |
| lfDout | output | 16 | Left port registered read data |
| lfBusyOutN | output | 1 | Left busy output, active low, driven in master mode |
| rtAddr | input | 11 | Right port word address |
| rtDin | input | 16 | Right port write data |
| rtCeN | input | 1 | Right port enable, active low |
| rtWeN | input | 2 | Right byte write enables, active low (bit 1 upper, bit 0 lower) |
| rtBusyInN | input | 1 | Right busy input, active low, used in slave mode |
| rtDout | output | 16 | Right port registered read data |
| rtBusyOutN | output | 1 | Right busy output, active low, driven in master mode |

## Verification
Busy is combinational from the current inputs and the state registered on the last edge. The bench therefore samples it one nanosecond after it drives inputs on the falling edge, before the next rising edge. Read data shows up one rising edge after the read and is compared at the next falling edge against a word the bench predicted before that edge, so a same-edge write on the other port must not show yet. Writes go into the bench's reference array at the edge where they are predicted to happen: at the release edge for held-off writes, and never for blocked ones.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  // Which side owns a contested word
  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } dprSide_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrHiL;
    logic wrLoL;
    logic wrHiR;
    logic wrLoR;
    logic rdL;
    logic rdR;
  } dprStrobes_t;

endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lfAddr,
  input  logic              lfEn,
  input  logic [ADDR_W-1:0] rtAddr,
  input  logic              rtEn,
  output logic              lfLoses,
  output logic              rtLoses
);

  logic [ADDR_W-1:0] lfAddrQ, rtAddrQ;
  logic              lfEnQ, rtEnQ;
  logic              sameLocQ;
  dprSide_e          ownerQ;

  logic     sameLoc;
  logic     lfStayed, rtStayed, keepOwner;
  dprSide_e freshOwner, owner;

  assign sameLoc  = lfEn && rtEn && (lfAddr == rtAddr);
  assign lfStayed = lfEnQ && (lfAddrQ == lfAddr);
  assign rtStayed = rtEnQ && (rtAddrQ == rtAddr);

  // The earlier arrival wins; a tie goes to the left side
  assign freshOwner = (rtStayed && !lfStayed) ? SIDE_RIGHT : SIDE_LEFT;
  assign keepOwner  = sameLocQ && lfStayed && rtStayed;
  assign owner      = keepOwner ? ownerQ : freshOwner;

  assign lfLoses = sameLoc && (owner == SIDE_RIGHT);
  assign rtLoses = sameLoc && (owner == SIDE_LEFT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfAddrQ  <= '0;
      rtAddrQ  <= '0;
      lfEnQ    <= 1'b0;
      rtEnQ    <= 1'b0;
      sameLocQ <= 1'b0;
      ownerQ   <= SIDE_LEFT;
    end else begin
      lfAddrQ  <= lfAddr;
      rtAddrQ  <= rtAddr;
      lfEnQ    <= lfEn;
      rtEnQ    <= rtEn;
      sameLocQ <= sameLoc;
      ownerQ   <= owner;
    end
  end

endmodule

// File: rtl/dpr_ctrl.sv
module dpr_ctrl
  import dpr_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int IS_MASTER = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lfAddr,
  input  logic              lfCeN,
  input  logic [1:0]        lfWeN,
  input  logic              lfBusyInN,
  input  logic [ADDR_W-1:0] rtAddr,
  input  logic              rtCeN,
  input  logic [1:0]        rtWeN,
  input  logic              rtBusyInN,
  output logic              lfBusyOutN,
  output logic              rtBusyOutN,
  output dprStrobes_t       strobes
);

  localparam bit MASTER = (IS_MASTER != 0);

  logic lfEn, rtEn;
  logic lfLoses, rtLoses;
  logic lfHold, rtHold;

  assign lfEn = !lfCeN;
  assign rtEn = !rtCeN;

  dpr_arbiter #(
    .ADDR_W (ADDR_W)
  ) u_arb (
    .clk     (clk),
    .rstN    (rstN),
    .lfAddr  (lfAddr),
    .lfEn    (lfEn),
    .rtAddr  (rtAddr),
    .rtEn    (rtEn),
    .lfLoses (lfLoses),
    .rtLoses (rtLoses)
  );

  // Master: own decision; slave: obey the busy inputs
  assign lfHold = MASTER ? lfLoses : !lfBusyInN;
  assign rtHold = MASTER ? rtLoses : !rtBusyInN;

  assign lfBusyOutN = MASTER ? !lfLoses : 1'b1;
  assign rtBusyOutN = MASTER ? !rtLoses : 1'b1;

  always_comb begin
    strobes       = '0;
    strobes.rdL   = lfEn;
    strobes.rdR   = rtEn;
    strobes.wrHiL = lfEn && !lfWeN[1] && !lfHold;
    strobes.wrLoL = lfEn && !lfWeN[0] && !lfHold;
    strobes.wrHiR = rtEn && !rtWeN[1] && !rtHold;
    strobes.wrLoR = rtEn && !rtWeN[0] && !rtHold;
  end

endmodule

// File: rtl/dpr_datapath.sv
module dpr_datapath
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lfAddr,
  input  logic [DATA_W-1:0] lfDin,
  input  logic [ADDR_W-1:0] rtAddr,
  input  logic [DATA_W-1:0] rtDin,
  input  dprStrobes_t       strobes,
  output logic [DATA_W-1:0] lfDout,
  output logic [DATA_W-1:0] rtDout
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;

  logic [LANES-1:0] wrL, wrR;
  assign wrL = {strobes.wrHiL, strobes.wrLoL};
  assign wrR = {strobes.wrHiR, strobes.wrLoR};

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] lfQ, rtQ;

    // Right is applied last if both hit one word (slave mode only)
    always_ff @(posedge clk) begin
      if (wrL[g]) store[lfAddr] <= lfDin[g*LANE_W +: LANE_W];
      if (wrR[g]) store[rtAddr] <= rtDin[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lfQ <= '0;
        rtQ <= '0;
      end else begin
        if (strobes.rdL) lfQ <= store[lfAddr];
        if (strobes.rdR) rtQ <= store[rtAddr];
      end
    end

    assign lfDout[g*LANE_W +: LANE_W] = lfQ;
    assign rtDout[g*LANE_W +: LANE_W] = rtQ;
  end

endmodule

// File: rtl/dualport_busy_ram.sv
module dualport_busy_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 16,
  parameter int IS_MASTER = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lfAddr,
  input  logic [DATA_W-1:0] lfDin,
  input  logic              lfCeN,
  input  logic [1:0]        lfWeN,
  input  logic              lfBusyInN,
  output logic [DATA_W-1:0] lfDout,
  output logic              lfBusyOutN,
  input  logic [ADDR_W-1:0] rtAddr,
  input  logic [DATA_W-1:0] rtDin,
  input  logic              rtCeN,
  input  logic [1:0]        rtWeN,
  input  logic              rtBusyInN,
  output logic [DATA_W-1:0] rtDout,
  output logic              rtBusyOutN
);

  dprStrobes_t strobes;

  dpr_ctrl #(
    .ADDR_W    (ADDR_W),
    .IS_MASTER (IS_MASTER)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lfAddr     (lfAddr),
    .lfCeN      (lfCeN),
    .lfWeN      (lfWeN),
    .lfBusyInN  (lfBusyInN),
    .rtAddr     (rtAddr),
    .rtCeN      (rtCeN),
    .rtWeN      (rtWeN),
    .rtBusyInN  (rtBusyInN),
    .lfBusyOutN (lfBusyOutN),
    .rtBusyOutN (rtBusyOutN),
    .strobes    (strobes)
  );

  dpr_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .lfAddr  (lfAddr),
    .lfDin   (lfDin),
    .rtAddr  (rtAddr),
    .rtDin   (rtDin),
    .strobes (strobes),
    .lfDout  (lfDout),
    .rtDout  (rtDout)
  );

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker
  import dpr_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int IS_MASTER = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] lfAddr,
  input logic              lfCeN,
  input logic              lfBusyInN,
  input logic              lfBusyOutN,
  input logic [ADDR_W-1:0] rtAddr,
  input logic              rtCeN,
  input logic              rtBusyInN,
  input logic              rtBusyOutN,
  input dprStrobes_t       strobes
);

  localparam bit MASTER = (IS_MASTER != 0);

  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  logic match;
  assign match = !lfCeN && !rtCeN && (lfAddr == rtAddr);

  p_one_loser_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(!lfBusyOutN && !rtBusyOutN));

  p_match_flags_r5: assert property (@(posedge clk) disable iff (!rstN)
    (MASTER && match) |-> (!lfBusyOutN || !rtBusyOutN));

  p_busy_needs_match_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!lfBusyOutN || !rtBusyOutN) |-> match);

  p_early_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (MASTER && pastOk && match && $past(!lfCeN) && ($past(lfAddr) == lfAddr)
     && !($past(!rtCeN) && ($past(rtAddr) == rtAddr))) |-> !rtBusyOutN);

  p_tie_left_r7: assert property (@(posedge clk) disable iff (!rstN)
    (MASTER && pastOk && match
     && !($past(!lfCeN) && ($past(lfAddr) == lfAddr))
     && !($past(!rtCeN) && ($past(rtAddr) == rtAddr))) |-> !rtBusyOutN);

  p_keep_owner_r12: assert property (@(posedge clk) disable iff (!rstN)
    (MASTER && pastOk && match && $past(match) && ($past(lfAddr) == lfAddr)
     && ($past(rtAddr) == rtAddr) && $past(!rtBusyOutN)) |-> !rtBusyOutN);

  p_blocked_left_r8: assert property (@(posedge clk) disable iff (!rstN)
    !lfBusyOutN |-> !(strobes.wrHiL || strobes.wrLoL));

  p_blocked_right_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rtBusyOutN |-> !(strobes.wrHiR || strobes.wrLoR));

  p_slave_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !MASTER |-> (lfBusyOutN && rtBusyOutN));

  p_slave_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!MASTER && (!lfBusyInN || !rtBusyInN)) |->
      !((!lfBusyInN && (strobes.wrHiL || strobes.wrLoL)) ||
        (!rtBusyInN && (strobes.wrHiR || strobes.wrLoR))));

endmodule

bind dualport_busy_ram dpr_checker #(
  .ADDR_W    (ADDR_W),
  .IS_MASTER (IS_MASTER)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .lfAddr     (lfAddr),
  .lfCeN      (lfCeN),
  .lfBusyInN  (lfBusyInN),
  .lfBusyOutN (lfBusyOutN),
  .rtAddr     (rtAddr),
  .rtCeN      (rtCeN),
  .rtBusyInN  (rtBusyInN),
  .rtBusyOutN (rtBusyOutN),
  .strobes    (strobes)
);

// File: tb/dualport_busy_ram_tb.sv
`timescale 1ns/1ps
module dualport_busy_ram_tb;

  localparam int WD_CYCLES = 200000;
  localparam int NVEC      = 16;

  typedef struct packed {
    logic        lCe;
    logic [1:0]  lWe;
    logic [10:0] lA;
    logic [15:0] lD;
    logic        rCe;
    logic [1:0]  rWe;
    logic [10:0] rA;
    logic [15:0] rD;
    logic        eBL;
    logic        eBR;
  } vec_t;

  // R5/R6/R7/R8/R9/R12 busy patterns, R1/R2/R4 data through the reference
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'b00, 11'h010, 16'h1111, 1'b1, 2'b11, 11'h000, 16'h0000, 1'b1, 1'b1},
    '{1'b0, 2'b11, 11'h010, 16'h0000, 1'b0, 2'b00, 11'h020, 16'h2222, 1'b1, 1'b1},
    '{1'b0, 2'b00, 11'h030, 16'hAAAA, 1'b0, 2'b00, 11'h030, 16'h5555, 1'b1, 1'b0},
    '{1'b1, 2'b11, 11'h000, 16'h0000, 1'b0, 2'b00, 11'h030, 16'h5555, 1'b1, 1'b1},
    '{1'b0, 2'b11, 11'h030, 16'h0000, 1'b1, 2'b11, 11'h000, 16'h0000, 1'b1, 1'b1},
    '{1'b0, 2'b00, 11'h040, 16'h0404, 1'b1, 2'b11, 11'h000, 16'h0000, 1'b1, 1'b1},
    '{1'b0, 2'b11, 11'h040, 16'h0000, 1'b0, 2'b00, 11'h040, 16'h7777, 1'b1, 1'b0},
    '{1'b0, 2'b11, 11'h040, 16'h0000, 1'b0, 2'b00, 11'h040, 16'h7777, 1'b1, 1'b0},
    '{1'b1, 2'b11, 11'h000, 16'h0000, 1'b0, 2'b00, 11'h050, 16'h5050, 1'b1, 1'b1},
    '{1'b0, 2'b00, 11'h050, 16'h0A0A, 1'b0, 2'b11, 11'h050, 16'h0000, 1'b0, 1'b1},
    '{1'b0, 2'b00, 11'h050, 16'h0A0A, 1'b0, 2'b11, 11'h051, 16'h0000, 1'b1, 1'b1},
    '{1'b0, 2'b01, 11'h010, 16'hBEEF, 1'b0, 2'b10, 11'h020, 16'hCAFE, 1'b1, 1'b1},
    '{1'b0, 2'b11, 11'h010, 16'h0000, 1'b0, 2'b11, 11'h020, 16'h0000, 1'b1, 1'b1},
    '{1'b0, 2'b11, 11'h050, 16'h0000, 1'b0, 2'b11, 11'h050, 16'h0000, 1'b1, 1'b0},
    '{1'b1, 2'b11, 11'h000, 16'h0000, 1'b0, 2'b11, 11'h050, 16'h0000, 1'b1, 1'b1},
    '{1'b1, 2'b11, 11'h000, 16'h0000, 1'b1, 2'b11, 11'h000, 16'h0000, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] lfAddr = '0, rtAddr = '0;
  logic [15:0] lfDin = '0, rtDin = '0;
  logic        lfCeN = 1'b1, rtCeN = 1'b1;
  logic [1:0]  lfWeN = 2'b11, rtWeN = 2'b11;
  logic        lfBusyInN = 1'b1, rtBusyInN = 1'b1;
  logic [15:0] lfDout, rtDout, sLfDout, sRtDout;
  logic        lfBusyOutN, rtBusyOutN, sLfBusyOutN, sRtBusyOutN;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [15:0] refMem [2048];
  bit          refOk  [2048];

  always #2 clk = ~clk;

  dualport_busy_ram #(.ADDR_W(11), .DATA_W(16), .IS_MASTER(1)) u_dut (
    .clk(clk), .rstN(rstN),
    .lfAddr(lfAddr), .lfDin(lfDin), .lfCeN(lfCeN), .lfWeN(lfWeN),
    .lfBusyInN(lfBusyInN), .lfDout(lfDout), .lfBusyOutN(lfBusyOutN),
    .rtAddr(rtAddr), .rtDin(rtDin), .rtCeN(rtCeN), .rtWeN(rtWeN),
    .rtBusyInN(rtBusyInN), .rtDout(rtDout), .rtBusyOutN(rtBusyOutN)
  );

  dualport_busy_ram #(.ADDR_W(11), .DATA_W(16), .IS_MASTER(0)) u_slv (
    .clk(clk), .rstN(rstN),
    .lfAddr(lfAddr), .lfDin(lfDin), .lfCeN(lfCeN), .lfWeN(lfWeN),
    .lfBusyInN(lfBusyInN), .lfDout(sLfDout), .lfBusyOutN(sLfBusyOutN),
    .rtAddr(rtAddr), .rtDin(rtDin), .rtCeN(rtCeN), .rtWeN(rtWeN),
    .rtBusyInN(rtBusyInN), .rtDout(sRtDout), .rtBusyOutN(sRtBusyOutN)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drv(input logic lc, input logic [1:0] lw, input logic [10:0] la,
                     input logic [15:0] ld, input logic rc, input logic [1:0] rw,
                     input logic [10:0] ra, input logic [15:0] rd,
                     input logic lbi, input logic rbi);
    lfCeN = lc; lfWeN = lw; lfAddr = la; lfDin = ld;
    rtCeN = rc; rtWeN = rw; rtAddr = ra; rtDin = rd;
    lfBusyInN = lbi; rtBusyInN = rbi;
  endtask

  task automatic refWrite(input logic [10:0] a, input logic [1:0] we, input logic [15:0] d);
    if (!we[1]) refMem[a][15:8] = d[15:8];
    if (!we[0]) refMem[a][7:0]  = d[7:0];
    if (we != 2'b11) refOk[a] = 1'b1;
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic        pendL, pendR;
    logic [15:0] expL, expR;
    for (int a = 0; a < 2048; a++) begin
      refOk[a]  = 1'b0;
      refMem[a] = '0;
    end
    pendL = 1'b0; pendR = 1'b0; expL = '0; expR = '0;

    // Reset state
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R3 reset lfDout", {16'h0, lfDout}, 32'h0);
    chk("R3 reset rtDout", {16'h0, rtDout}, 32'h0);
    chk("R9 reset lfBusyOutN", {31'h0, lfBusyOutN}, 32'h1);
    chk("R9 reset rtBusyOutN", {31'h0, rtBusyOutN}, 32'h1);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      if (pendL) chk($sformatf("R1/R2/R4 step%0d lfDout", i-1), {16'h0, lfDout}, {16'h0, expL});
      if (pendR) chk($sformatf("R1/R2/R4 step%0d rtDout", i-1), {16'h0, rtDout}, {16'h0, expR});
      drv(VECS[i].lCe, VECS[i].lWe, VECS[i].lA, VECS[i].lD,
          VECS[i].rCe, VECS[i].rWe, VECS[i].rA, VECS[i].rD, 1'b1, 1'b1);
      #1;
      chk($sformatf("R5/R6/R7/R9/R12 step%0d lfBusyOutN", i), {31'h0, lfBusyOutN}, {31'h0, VECS[i].eBL});
      chk($sformatf("R5/R6/R7/R9/R12 step%0d rtBusyOutN", i), {31'h0, rtBusyOutN}, {31'h0, VECS[i].eBR});
      pendL = !VECS[i].lCe && refOk[VECS[i].lA];
      pendR = !VECS[i].rCe && refOk[VECS[i].rA];
      expL  = refMem[VECS[i].lA];
      expR  = refMem[VECS[i].rA];
      // R8: a port with expected busy low writes nothing
      if (!VECS[i].lCe && VECS[i].eBL) refWrite(VECS[i].lA, VECS[i].lWe, VECS[i].lD);
      if (!VECS[i].rCe && VECS[i].eBR) refWrite(VECS[i].rA, VECS[i].rWe, VECS[i].rD);
      @(negedge clk);
    end
    if (pendL) chk("R1/R2/R4 last lfDout", {16'h0, lfDout}, {16'h0, expL});
    if (pendR) chk("R1/R2/R4 last rtDout", {16'h0, rtDout}, {16'h0, expR});

    // R1: disabled port and write-enables-high do not write
    drv(1'b0, 2'b00, 11'h060, 16'h1234, 1'b1, 2'b11, 11'h000, 16'h0, 1'b1, 1'b1);
    @(negedge clk);
    drv(1'b1, 2'b00, 11'h060, 16'hFFFF, 1'b1, 2'b11, 11'h000, 16'h0, 1'b1, 1'b1);
    @(negedge clk);
    drv(1'b0, 2'b11, 11'h060, 16'hFFFF, 1'b1, 2'b11, 11'h000, 16'h0, 1'b1, 1'b1);
    @(negedge clk);
    @(negedge clk);
    chk("R1 no write when disabled or we high", {16'h0, lfDout}, 32'h1234);
    // R3: output holds while disabled
    drv(1'b1, 2'b11, 11'h010, 16'h0, 1'b1, 2'b11, 11'h000, 16'h0, 1'b1, 1'b1);
    @(negedge clk);
    chk("R3 hold while disabled", {16'h0, lfDout}, 32'h1234);

    // R10/R11: busy inputs in master and slave
    drv(1'b0, 2'b00, 11'h100, 16'h0000, 1'b0, 2'b00, 11'h101, 16'h0000, 1'b1, 1'b1);
    @(negedge clk);
    drv(1'b0, 2'b00, 11'h100, 16'h3C3C, 1'b0, 2'b00, 11'h101, 16'h4B4B, 1'b0, 1'b1);
    @(negedge clk);
    drv(1'b0, 2'b11, 11'h100, 16'h0, 1'b0, 2'b11, 11'h101, 16'h0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R11 master ignores busy input", {16'h0, lfDout}, 32'h3C3C);
    chk("R10 slave left write held off", {16'h0, sLfDout}, 32'h0000);
    chk("R10 slave right write proceeds", {16'h0, sRtDout}, 32'h4B4B);
    drv(1'b0, 2'b00, 11'h100, 16'h3C3C, 1'b1, 2'b11, 11'h000, 16'h0, 1'b1, 1'b1);
    @(negedge clk);
    drv(1'b0, 2'b11, 11'h100, 16'h0, 1'b0, 2'b11, 11'h101, 16'h0, 1'b1, 1'b1);
    @(negedge clk);
    chk("R8 slave write completes after release", {16'h0, sLfDout}, 32'h3C3C);
    drv(1'b0, 2'b11, 11'h100, 16'h0, 1'b0, 2'b11, 11'h100, 16'h0, 1'b1, 1'b1);
    #1;
    chk("R10 slave lfBusyOutN high on match", {31'h0, sLfBusyOutN}, 32'h1);
    chk("R10 slave rtBusyOutN high on match", {31'h0, sRtBusyOutN}, 32'h1);
    chk("R6 master earlier left wins", {31'h0, rtBusyOutN}, 32'h0);
    chk("R6 master left not busy", {31'h0, lfBusyOutN}, 32'h1);
    @(negedge clk);
    drv(1'b1, 2'b11, 11'h000, 16'h0, 1'b1, 2'b11, 11'h000, 16'h0, 1'b1, 1'b1);
    @(negedge clk);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule